// File: doc/BRIEF.md
# Compact Order Unpacking Dispatcher

This block takes one compact order per clock and turns it into the per-port routing controls of a calculation unit that has several data input ports and several data output ports. Each order is a fixed-width word. It holds an operation-select field, a port-occupancy bitmap and a packed table of storage addresses. The table carries an entry only for each port marked busy. The dispatcher works out which table entry belongs to which busy port, spreads the entries onto fixed per-port slots, and registers the result. The registered result drives the operation-select lines, the input-port address controller and the output-port address controller.

A port marked vacant has its valid flag cleared, and its address output keeps its last value. A vacant input port can therefore go on presenting data that was latched earlier. A stall freezes every output and drops the order presented in that cycle. When no order is offered and there is no stall, all valid flags clear on the next edge.

Top module: `order_unpack_dispatch`

## Requirements
- R1: While `rst_n` is low, every valid flag, select code, address and region output is 0.
- R2: An accepted order (`instr_valid`=1, `stall`=0) sets `sel_valid`=1 on the next edge, and `sel_code` takes bits [NP+SEL_W-1:NP] of the order, where NP = N_IN+N_OUT.
- R3: After an accepted order, the valid flag of port p equals bitmap bit p of the order (bits [NP-1:0]). Bits 0..N_IN-1 are input ports 0..N_IN-1. Bits N_IN..NP-1 are output ports 0..N_OUT-1.
- R4: A busy port p receives table slot k, where k is the number of busy ports with a lower bitmap index. This places all input ports ahead of all output ports.
- R5: Table slot k occupies order bits starting at NP+SEL_W+k*(ADDR_W+1). Within a slot, the low ADDR_W bits are the address and the top bit is the region flag (0 = local storage, 1 = shared area).
- R6: After an accepted order, the address and region outputs of each vacant port keep their previous values.
- R7: Table slots at positions equal to or above the bitmap popcount have no effect on any output.
- R8: With `stall`=1, every output keeps its value on the next edge and the order offered in that cycle is discarded.
- R9: With `instr_valid`=0 and `stall`=0, `sel_valid` and every port valid flag are 0 on the next edge. Addresses, regions and `sel_code` hold.
- R10: Orders offered on consecutive cycles without a stall are each accepted, and each appears at the outputs exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze outputs and discard the offered order |
| instr_valid | input | 1 | An order is offered this cycle |
| instr | input | NP+SEL_W+NP*(ADDR_W+1) | Order word: bitmap, select field, packed table |
| sel_valid | output | 1 | Select code is live this cycle |
| sel_code | output | SEL_W | Operation-select lines |
| in_valid | output | N_IN | Input port busy flags |
| in_addr | output | N_IN*ADDR_W | Input port addresses, port 0 in the low bits |
| in_shared | output | N_IN | Input port region flags |
| out_valid | output | N_OUT | Output port busy flags |
| out_addr | output | N_OUT*ADDR_W | Output port addresses, port 0 in the low bits |
| out_shared | output | N_OUT | Output port region flags |

## Verification
Within a single order, a busy port may be loaded with a new address in the same cycle that a vacant neighbour must hold its old one. Sparse bitmaps that follow a full bitmap provoke this case, and the bench compares every port against a behavioural model that counts ranks with plain integers. A stall can also coincide with a valid order. The bench raises both together and requires that the outputs are frozen and that the dropped order never shows up later. Random back-to-back traffic mixes these collisions with idle cycles.

// File: rtl/oud_pkg.sv
`timescale 1ns/1ps
package oud_pkg;

   // Width needed to hold a slot index 0..np-1.
   function automatic int rank_width(input int np);
      return (np > 1) ? $clog2(np) : 1;
   endfunction

   typedef enum logic {
      REGION_LOCAL  = 1'b0,
      REGION_SHARED = 1'b1
   } region_e;

endpackage

// File: rtl/oud_rank.sv
`timescale 1ns/1ps
// Per-port slot index: number of busy ports below each port.
module oud_rank #(
   parameter int NP = 6,
   parameter int RW = 3
) (
   input  logic [NP-1:0]    busy,
   output logic [NP*RW-1:0] rank
);

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         if (p == 0) begin : g_first
            assign rank[RW-1:0] = '0;
         end else begin : g_rest
            logic [RW-1:0] cnt;
            always_comb begin
               cnt = '0;
               for (int b = 0; b < p; b++) begin
                  cnt = cnt + RW'(busy[b]);
               end
            end
            assign rank[p*RW +: RW] = cnt;
         end
      end
   endgenerate

endmodule

// File: rtl/oud_slot_mux.sv
`timescale 1ns/1ps
// Picks the table slot for each port. Port p can only ever need slots 0..p,
// so each port's mux is cut to p+1 inputs.
module oud_slot_mux #(
   parameter int NP    = 6,
   parameter int RW    = 3,
   parameter int FLD_W = 8
) (
   input  logic [NP*FLD_W-1:0] table_in,
   input  logic [NP*RW-1:0]    rank,
   output logic [NP*FLD_W-1:0] field
);

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         logic [RW-1:0]    r;
         logic [FLD_W-1:0] f;
         assign r = rank[p*RW +: RW];
         always_comb begin
            f = '0;
            for (int s = 0; s <= p; s++) begin
               if (r == RW'(s)) f = table_in[s*FLD_W +: FLD_W];
            end
         end
         assign field[p*FLD_W +: FLD_W] = f;
      end
   endgenerate

endmodule

// File: rtl/oud_port_reg.sv
`timescale 1ns/1ps
// One port's registered routing state.
module oud_port_reg #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              take,
   input  logic              busy,
   input  logic [ADDR_W:0]   fld,
   output logic              valid_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              shared_q
);

   logic load;
   assign load = take & busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         addr_q   <= '0;
         shared_q <= oud_pkg::REGION_LOCAL;
      end else if (adv) begin
         valid_q <= load;
         if (load) begin
            addr_q   <= fld[ADDR_W-1:0];
            shared_q <= fld[ADDR_W];
         end
      end
   end

   assert_vacant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && take && !busy) |=> ($stable(addr_q) && $stable(shared_q)));

   assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv) |=> ($stable(valid_q) && $stable(addr_q) && $stable(shared_q)));

   assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !take) |=> (!valid_q && $stable(addr_q)));

   assert_busy_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && take && busy) |=> (valid_q && addr_q == $past(fld[ADDR_W-1:0])));

endmodule

// File: rtl/order_unpack_dispatch.sv
`timescale 1ns/1ps
module order_unpack_dispatch #(
   parameter int N_IN   = 4,
   parameter int N_OUT  = 2,
   parameter int SEL_W  = 5,
   parameter int ADDR_W = 7,
   localparam int NP      = N_IN + N_OUT,
   localparam int FLD_W   = ADDR_W + 1,
   localparam int SEL_LSB = NP,
   localparam int TBL_LSB = NP + SEL_W,
   localparam int INSTR_W = TBL_LSB + NP * FLD_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    stall,
   input  logic                    instr_valid,
   input  logic [INSTR_W-1:0]      instr,
   output logic                    sel_valid,
   output logic [SEL_W-1:0]        sel_code,
   output logic [N_IN-1:0]         in_valid,
   output logic [N_IN*ADDR_W-1:0]  in_addr,
   output logic [N_IN-1:0]         in_shared,
   output logic [N_OUT-1:0]        out_valid,
   output logic [N_OUT*ADDR_W-1:0] out_addr,
   output logic [N_OUT-1:0]        out_shared
);

   localparam int RW = oud_pkg::rank_width(NP);

   // Elaboration-time parameter checks
   if (N_IN < 1)   begin : g_bad_in   $error("N_IN must be at least 1");   end
   if (N_OUT < 1)  begin : g_bad_out  $error("N_OUT must be at least 1");  end
   if (SEL_W < 1)  begin : g_bad_sel  $error("SEL_W must be at least 1");  end
   if (ADDR_W < 1) begin : g_bad_addr $error("ADDR_W must be at least 1"); end

   logic                adv, take;
   logic [NP-1:0]       bitmap;
   logic [SEL_W-1:0]    sel_f;
   logic [NP*FLD_W-1:0] table_f;
   logic [NP*RW-1:0]    rank;
   logic [NP*FLD_W-1:0] field;
   logic [NP-1:0]       pv;
   logic [NP*ADDR_W-1:0] pa;
   logic [NP-1:0]       ps;

   assign adv     = ~stall;
   assign take    = instr_valid;
   assign bitmap  = instr[NP-1:0];
   assign sel_f   = instr[SEL_LSB +: SEL_W];
   assign table_f = instr[TBL_LSB +: NP*FLD_W];

   oud_rank #(.NP(NP), .RW(RW)) i_rank (
      .busy (bitmap),
      .rank (rank)
   );

   oud_slot_mux #(.NP(NP), .RW(RW), .FLD_W(FLD_W)) i_mux (
      .table_in (table_f),
      .rank     (rank),
      .field    (field)
   );

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         oud_port_reg #(.ADDR_W(ADDR_W)) i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (adv),
            .take     (take),
            .busy     (bitmap[p]),
            .fld      (field[p*FLD_W +: FLD_W]),
            .valid_q  (pv[p]),
            .addr_q   (pa[p*ADDR_W +: ADDR_W]),
            .shared_q (ps[p])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid <= 1'b0;
         sel_code  <= '0;
      end else if (adv) begin
         sel_valid <= take;
         if (take) sel_code <= sel_f;
      end
   end

   assign in_valid   = pv[N_IN-1:0];
   assign out_valid  = pv[NP-1:N_IN];
   assign in_addr    = pa[N_IN*ADDR_W-1:0];
   assign out_addr   = pa[NP*ADDR_W-1:N_IN*ADDR_W];
   assign in_shared  = ps[N_IN-1:0];
   assign out_shared = ps[NP-1:N_IN];

   assert_sel_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !stall) |=> (sel_valid && sel_code == $past(instr[SEL_LSB +: SEL_W])));

   assert_busy_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !stall) |=>
         ($countones({out_valid, in_valid}) == $countones($past(instr[NP-1:0]))));

   assert_sel_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(sel_valid) && $stable(sel_code)));

endmodule

// File: tb/test_order_unpack_dispatch.sv
`timescale 1ns/1ps
module test_order_unpack_dispatch;

   localparam int N_IN = 4, N_OUT = 2, SEL_W = 5, ADDR_W = 7;
   localparam int NP = N_IN + N_OUT;
   localparam int FLD_W = ADDR_W + 1;
   localparam int TBL_LSB = NP + SEL_W;
   localparam int W = TBL_LSB + NP * FLD_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stall = 1'b0;
   logic instr_valid = 1'b0;
   logic [W-1:0] instr = '0;
   logic sel_valid;
   logic [SEL_W-1:0] sel_code;
   logic [N_IN-1:0] in_valid, in_shared;
   logic [N_IN*ADDR_W-1:0] in_addr;
   logic [N_OUT-1:0] out_valid, out_shared;
   logic [N_OUT*ADDR_W-1:0] out_addr;

   always #5 clk = ~clk;

   order_unpack_dispatch #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W))
   i_order_unpack_dispatch (
      .clk(clk), .rst_n(rst_n), .stall(stall), .instr_valid(instr_valid), .instr(instr),
      .sel_valid(sel_valid), .sel_code(sel_code),
      .in_valid(in_valid), .in_addr(in_addr), .in_shared(in_shared),
      .out_valid(out_valid), .out_addr(out_addr), .out_shared(out_shared)
   );

   // Behavioural reference model
   logic             m_selv = 1'b0;
   logic [SEL_W-1:0] m_sel = '0;
   logic             m_val [NP];
   logic [ADDR_W-1:0] m_addr [NP];
   logic             m_sh [NP];
   initial for (int p = 0; p < NP; p++) begin m_val[p] = 0; m_addr[p] = '0; m_sh[p] = 0; end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_selv <= 1'b0; m_sel <= '0;
         for (int p = 0; p < NP; p++) begin m_val[p] <= 0; m_addr[p] <= '0; m_sh[p] <= 0; end
      end else if (!stall) begin
         int k;
         logic [FLD_W-1:0] f;
         k = 0;
         m_selv <= instr_valid;
         if (instr_valid) m_sel <= instr[NP +: SEL_W];
         for (int p = 0; p < NP; p++) begin
            m_val[p] <= instr_valid && instr[p];
            if (instr_valid && instr[p]) begin
               f = instr[TBL_LSB + k*FLD_W +: FLD_W];
               m_addr[p] <= f[ADDR_W-1:0];
               m_sh[p]   <= f[ADDR_W];
               k++;
            end
         end
      end
   end

   int vectors = 0, fails = 0;
   bit done = 0;
   string tag = "R1";

   task automatic chk(input string t, input string what, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", t, what, act, exp, $time);
      end
   endtask

   task automatic compare(input string t);
      chk(t, "sel_valid (R2)", sel_valid, m_selv);
      chk(t, "sel_code (R2)", sel_code, m_sel);
      for (int p = 0; p < NP; p++) begin
         logic v, s; logic [ADDR_W-1:0] a;
         if (p < N_IN) begin
            v = in_valid[p]; s = in_shared[p]; a = in_addr[p*ADDR_W +: ADDR_W];
         end else begin
            v = out_valid[p-N_IN]; s = out_shared[p-N_IN];
            a = out_addr[(p-N_IN)*ADDR_W +: ADDR_W];
         end
         chk(t, $sformatf("port%0d valid (R3)", p), v, m_val[p]);
         chk(t, $sformatf("port%0d addr (R4)", p), a, m_addr[p]);
         chk(t, $sformatf("port%0d region (R5)", p), s, m_sh[p]);
      end
   endtask

   // Compare the result of the previous cycle, then drive the next one.
   task automatic cyc(input logic iv, input logic st, input logic [W-1:0] w, input string t);
      @(negedge clk);
      compare(tag);
      tag = t;
      instr_valid = iv; stall = st; instr = w;
   endtask

   function automatic logic [W-1:0] mk(input logic [SEL_W-1:0] sel, input logic [NP-1:0] bm,
                                       input logic [NP*FLD_W-1:0] tbl);
      return {tbl, sel, bm};
   endfunction

   function automatic logic [NP*FLD_W-1:0] ramp(input int base);
      logic [NP*FLD_W-1:0] r;
      for (int s = 0; s < NP; s++) r[s*FLD_W +: FLD_W] = FLD_W'(base + 17*s);
      return r;
   endfunction

   function automatic logic [W-1:0] rnd_word();
      logic [95:0] r;
      r = {$urandom, $urandom, $urandom};
      return r[W-1:0];
   endfunction

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      tag = "R1"; compare(tag);
      @(negedge clk); rst_n = 1'b1;
      // R2 R3 R4: full bitmap, every slot used
      cyc(1, 0, mk(5'h13, 6'b111111, ramp(8'h21)), "R4");
      cyc(1, 0, mk(5'h0a, 6'b111111, ramp(8'h90)), "R2");
      // R5: single busy port, region bit set; lone output port takes slot 0
      cyc(1, 0, mk(5'h01, 6'b000001, {40'h0, 8'hc5}), "R5");
      cyc(1, 0, mk(5'h02, 6'b100000, {40'h0, 8'hbb}), "R5");
      // R6: sparse bitmap, vacant ports hold
      cyc(1, 0, mk(5'h03, 6'b010010, ramp(8'h44)), "R6");
      cyc(1, 0, mk(5'h04, 6'b000000, ramp(8'h77)), "R6");
      // R7: junk in trailing slots
      cyc(1, 0, mk(5'h05, 6'b000101, {32'hffffffff, 8'h12, 8'h34}), "R7");
      cyc(1, 0, mk(5'h06, 6'b101000, {32'ha5a5a5a5, 8'h0f, 8'h8e}), "R7");
      // R8: stall with a valid order offered, order dropped
      cyc(1, 1, mk(5'h1f, 6'b111111, ramp(8'h03)), "R8");
      cyc(1, 1, mk(5'h1e, 6'b001100, ramp(8'h5c)), "R8");
      cyc(0, 1, '0, "R8");
      // R9: idle without stall
      cyc(0, 0, mk(5'h1d, 6'b111111, ramp(8'h66)), "R9");
      cyc(0, 0, '0, "R9");
      // R3 again: input ports only
      cyc(1, 0, mk(5'h07, 6'b001111, ramp(8'h31)), "R3");
      // R10: back-to-back random traffic with stalls and gaps
      for (int i = 0; i < 400; i++) begin
         cyc(($urandom % 8) != 0, ($urandom % 8) == 0, rnd_word(), "R10");
      end
      cyc(0, 0, '0, "R10");
      @(negedge clk); compare(tag);
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule